// File: doc/BRIEF.md
# Interrupt Message Intake and Delivery Selector

This block sits in front of one processor's local interrupt controller. It receives interrupt messages, keeps only those addressed to this processor, and sorts each one by its delivery-mode code. Vectored messages (fixed and lowest-priority) pass straight on to a separate request-register arbiter, together with their vector and trigger mode. Non-vectored events (system-management, non-maskable, init and external-interrupt) each go into a single-entry pending latch that also holds that event's vector.

Each cycle the selector merges these latches with the arbiter's "fixed interrupt ready" signal and the processor's interrupt-enable flag. It raises one interrupt request and reports the kind and vector of the event that wins the fixed precedence order. When the processor acknowledges, only the winning source is retired. A fixed-path acknowledge is passed on to the arbiter only when that path is the one that won.

Top module: `irq_intake_sel`

## Requirements
- R1: A message is accepted only when `msg_valid` is 1 and either `msg_dest_mode` is 0 and `msg_dest` equals `local_id` zero-extended, or `msg_dest_mode` is 1 and bit `local_id` of `msg_dest` is 1. A message that is not accepted changes no pending state and forwards nothing.
- R2: An accepted message with mode code 0 (fixed) or 1 (lowest priority) drives `fix_valid` high in the same cycle, with `fix_vector` and `fix_trig` copied from the message. It never sets a pending latch. When `fix_valid` is 0, `fix_vector` and `fix_trig` are 0.
- R3: Mode codes 3 and 6 are reserved. A message carrying either code is ignored: it sets no latch and forwards nothing.
- R4: Mode codes 2 (SMI), 4 (NMI), 5 (INIT) and 7 (ExtInt) each set their own pending latch, one cycle after acceptance, and store the message vector. A message of a kind whose latch is already set is dropped, and the stored vector is kept.
- R5: A pending SMI, NMI or INIT raises `irq_req` whatever the value of `int_enable`.
- R6: A pending ExtInt, and `fixed_ready`, raise `irq_req` only while `int_enable` is 1. With `int_enable` at 0 and no SMI, NMI or INIT pending, `irq_req` is 0.
- R7: Precedence is SMI > NMI > INIT > ExtInt > fixed. `irq_kind` encodes the winner as 0 none, 1 SMI, 2 NMI, 3 INIT, 4 ExtInt, 5 fixed. `irq_vector` is the stored vector for NMI, INIT and ExtInt, `fixed_vector` for fixed, and 0 for SMI or none.
- R8: `ack` while `irq_req` is 1 clears only the winning latch, at the next edge. `fix_ack` is 1 exactly when `ack` is 1 and the winner is fixed. `ack` while `irq_req` is 0 has no effect.
- R9: If a message of a kind arrives in the same cycle as the acknowledge that clears that kind, the new message is recorded, with its vector, after the clear.
- R10: A synchronous active-high `rst` clears every pending latch and stored vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_id | input | 3 | This processor's identifier |
| msg_valid | input | 1 | Message present this cycle |
| msg_dest_mode | input | 1 | 0 physical ID match, 1 bit-mask match |
| msg_dest | input | 8 | Destination field |
| msg_mode | input | 3 | Delivery-mode code |
| msg_vector | input | 8 | Message vector |
| msg_trig | input | 1 | Trigger mode (1 level, 0 edge) |
| fix_valid | output | 1 | Vectored message forwarded to the arbiter |
| fix_vector | output | 8 | Forwarded vector |
| fix_trig | output | 1 | Forwarded trigger mode |
| fixed_ready | input | 1 | Arbiter has a deliverable vectored interrupt |
| fixed_vector | input | 8 | Arbiter's winning vector |
| int_enable | input | 1 | Processor interrupt-enable flag |
| ack | input | 1 | Processor takes the reported interrupt |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_kind | output | 3 | Winning event kind |
| irq_vector | output | 8 | Winning event vector |
| fix_ack | output | 1 | Acknowledge passed to the arbiter |

## Verification
The embedded assertions check on every cycle that SMI, NMI and INIT always raise the request, that the enable flag gates everything else, and that an acknowledge clears at most one latch. They also check that a held latch keeps its vector, that reserved codes touch nothing, and that reset empties the bank. Only the bench's scenarios can show the full precedence order and the reported vectors across mixed pending sets. The same holds for dropping duplicates, the same-cycle acknowledge-and-arrival case, and the two address-matching modes with their mismatches.

// File: rtl/irq_intake_pkg.sv
package irq_intake_pkg;

    localparam int NSRC = 4;

    localparam int SRC_SMI  = 0;
    localparam int SRC_NMI  = 1;
    localparam int SRC_INIT = 2;
    localparam int SRC_EXT  = 3;

    localparam logic [2:0] MODE_FIXED  = 3'd0;
    localparam logic [2:0] MODE_LOWEST = 3'd1;
    localparam logic [2:0] MODE_SMI    = 3'd2;
    localparam logic [2:0] MODE_NMI    = 3'd4;
    localparam logic [2:0] MODE_INIT   = 3'd5;
    localparam logic [2:0] MODE_EXT    = 3'd7;

    typedef enum logic [2:0] {
        KIND_NONE  = 3'd0,
        KIND_SMI   = 3'd1,
        KIND_NMI   = 3'd2,
        KIND_INIT  = 3'd3,
        KIND_EXT   = 3'd4,
        KIND_FIXED = 3'd5
    } irq_kind_e;

    function automatic logic [2:0] src_mode(input int idx);
        case (idx)
            SRC_SMI:  return MODE_SMI;
            SRC_NMI:  return MODE_NMI;
            SRC_INIT: return MODE_INIT;
            default:  return MODE_EXT;
        endcase
    endfunction

endpackage

// File: rtl/irq_intake_filter.sv
module irq_intake_filter
    import irq_intake_pkg::*;
#(
    parameter int IDW = 3,
    parameter int VW  = 8,
    localparam int DW = 1 << IDW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IDW-1:0]  local_id,
    input  logic            msg_valid,
    input  logic            msg_dest_mode,
    input  logic [DW-1:0]   msg_dest,
    input  logic [2:0]      msg_mode,
    input  logic [VW-1:0]   msg_vector,
    input  logic            msg_trig,
    output logic [NSRC-1:0] hit_o,
    output logic            fix_valid_o,
    output logic [VW-1:0]   fix_vector_o,
    output logic            fix_trig_o
);

    logic addr_ok;
    logic is_vectored;

    always_comb begin
        if (msg_dest_mode) begin
            addr_ok = msg_dest[local_id];
        end else begin
            addr_ok = (msg_dest == DW'(local_id));
        end
    end

    assign is_vectored = (msg_mode == MODE_FIXED) || (msg_mode == MODE_LOWEST);

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_hit
            assign hit_o[g] = msg_valid && addr_ok && (msg_mode == src_mode(g));
        end
    endgenerate

    assign fix_valid_o  = msg_valid && addr_ok && is_vectored;
    assign fix_vector_o = fix_valid_o ? msg_vector : '0;
    assign fix_trig_o   = fix_valid_o && msg_trig;

    assert_reserved_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (msg_mode == 3'd3 || msg_mode == 3'd6) |-> (hit_o == '0 && !fix_valid_o));

    assert_no_msg_no_hit_R1: assert property (@(posedge clk) disable iff (rst)
        !msg_valid |-> (hit_o == '0 && !fix_valid_o));

    assert_single_path_R2: assert property (@(posedge clk) disable iff (rst)
        fix_valid_o |-> (hit_o == '0));

endmodule

// File: rtl/irq_intake_bank.sv
module irq_intake_bank
    import irq_intake_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSRC-1:0]          hit_i,
    input  logic [VW-1:0]            vec_i,
    input  logic [NSRC-1:0]          clr_i,
    output logic [NSRC-1:0]          pend_o,
    output logic [NSRC-1:1][VW-1:0]  vec_o
);

    typedef struct packed {
        logic [NSRC-1:0]         pend;
        logic [NSRC-1:1][VW-1:0] vec;
    } bank_t;

    bank_t st_d;
    bank_t st_q;
    logic [NSRC-1:0] take;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSRC; i++) begin
            take[i]      = hit_i[i] && (!st_q.pend[i] || clr_i[i]);
            st_d.pend[i] = (st_q.pend[i] && !clr_i[i]) || take[i];
        end
        for (int i = 1; i < NSRC; i++) begin
            if (take[i]) begin
                st_d.vec[i] = vec_i;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign vec_o  = st_q.vec;

    assert_reset_empties_R10: assert property (@(posedge clk)
        rst |=> (pend_o == '0 && vec_o == '0));

    generate
        for (genvar g = 1; g < NSRC; g++) begin : g_chk
            assert_held_vec_kept_R4: assert property (@(posedge clk) disable iff (rst)
                (pend_o[g] && !clr_i[g]) |=> (pend_o[g] && $stable(vec_o[g])));
        end
    endgenerate

endmodule

// File: rtl/irq_intake_select.sv
module irq_intake_select
    import irq_intake_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NSRC-1:0]      pend_i,
    input  logic [2:0][VW-1:0]   vec_i,
    input  logic                 int_enable,
    input  logic                 fixed_ready,
    input  logic [VW-1:0]        fixed_vector,
    input  logic                 ack,
    output logic                 irq_req_o,
    output irq_kind_e            kind_o,
    output logic [VW-1:0]        vector_o,
    output logic [NSRC-1:0]      clr_o,
    output logic                 fix_ack_o
);

    logic unmask_pend;

    assign unmask_pend = pend_i[SRC_SMI] || pend_i[SRC_NMI] || pend_i[SRC_INIT];

    always_comb begin
        kind_o   = KIND_NONE;
        vector_o = '0;
        if (pend_i[SRC_SMI]) begin
            kind_o = KIND_SMI;
        end else if (pend_i[SRC_NMI]) begin
            kind_o   = KIND_NMI;
            vector_o = vec_i[0];
        end else if (pend_i[SRC_INIT]) begin
            kind_o   = KIND_INIT;
            vector_o = vec_i[1];
        end else if (int_enable && pend_i[SRC_EXT]) begin
            kind_o   = KIND_EXT;
            vector_o = vec_i[2];
        end else if (int_enable && fixed_ready) begin
            kind_o   = KIND_FIXED;
            vector_o = fixed_vector;
        end
    end

    assign irq_req_o = (kind_o != KIND_NONE);

    always_comb begin
        clr_o     = '0;
        fix_ack_o = 1'b0;
        if (ack) begin
            case (kind_o)
                KIND_SMI:   clr_o[SRC_SMI]  = 1'b1;
                KIND_NMI:   clr_o[SRC_NMI]  = 1'b1;
                KIND_INIT:  clr_o[SRC_INIT] = 1'b1;
                KIND_EXT:   clr_o[SRC_EXT]  = 1'b1;
                KIND_FIXED: fix_ack_o       = 1'b1;
                default:    clr_o           = '0;
            endcase
        end
    end

    assert_unmaskable_req_R5: assert property (@(posedge clk) disable iff (rst)
        unmask_pend |-> irq_req_o);

    assert_enable_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (!int_enable && !unmask_pend) |-> !irq_req_o);

    assert_one_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({clr_o, fix_ack_o}));

    assert_fix_ack_alone_R8: assert property (@(posedge clk) disable iff (rst)
        fix_ack_o |-> (pend_i == '0 && ack));

    assert_idle_ack_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !irq_req_o |-> (clr_o == '0 && !fix_ack_o));

endmodule

// File: rtl/irq_intake_sel.sv
module irq_intake_sel
    import irq_intake_pkg::*;
#(
    parameter int IDW = 3,
    parameter int VW  = 8,
    localparam int DW = 1 << IDW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [IDW-1:0] local_id,
    input  logic           msg_valid,
    input  logic           msg_dest_mode,
    input  logic [DW-1:0]  msg_dest,
    input  logic [2:0]     msg_mode,
    input  logic [VW-1:0]  msg_vector,
    input  logic           msg_trig,
    output logic           fix_valid,
    output logic [VW-1:0]  fix_vector,
    output logic           fix_trig,
    input  logic           fixed_ready,
    input  logic [VW-1:0]  fixed_vector,
    input  logic           int_enable,
    input  logic           ack,
    output logic           irq_req,
    output logic [2:0]     irq_kind,
    output logic [VW-1:0]  irq_vector,
    output logic           fix_ack
);

    logic [NSRC-1:0]         hit;
    logic [NSRC-1:0]         clr;
    logic [NSRC-1:0]         pend;
    logic [NSRC-1:1][VW-1:0] held_vec;
    irq_kind_e               kind;

    irq_intake_filter #(.IDW(IDW), .VW(VW)) filter_i (
        .clk           (clk),
        .rst           (rst),
        .local_id      (local_id),
        .msg_valid     (msg_valid),
        .msg_dest_mode (msg_dest_mode),
        .msg_dest      (msg_dest),
        .msg_mode      (msg_mode),
        .msg_vector    (msg_vector),
        .msg_trig      (msg_trig),
        .hit_o         (hit),
        .fix_valid_o   (fix_valid),
        .fix_vector_o  (fix_vector),
        .fix_trig_o    (fix_trig)
    );

    irq_intake_bank #(.VW(VW)) bank_i (
        .clk    (clk),
        .rst    (rst),
        .hit_i  (hit),
        .vec_i  (msg_vector),
        .clr_i  (clr),
        .pend_o (pend),
        .vec_o  (held_vec)
    );

    irq_intake_select #(.VW(VW)) select_i (
        .clk          (clk),
        .rst          (rst),
        .pend_i       (pend),
        .vec_i        (held_vec),
        .int_enable   (int_enable),
        .fixed_ready  (fixed_ready),
        .fixed_vector (fixed_vector),
        .ack          (ack),
        .irq_req_o    (irq_req),
        .kind_o       (kind),
        .vector_o     (irq_vector),
        .clr_o        (clr),
        .fix_ack_o    (fix_ack)
    );

    assign irq_kind = kind;

    assert_vectored_never_latches_R2: assert property (@(posedge clk) disable iff (rst)
        (fix_valid && !irq_req) |=> !(pend[SRC_SMI] || pend[SRC_NMI] || pend[SRC_INIT]) || $past(pend != '0));

endmodule

// File: tb/irq_intake_sel_tb_top.sv
module irq_intake_sel_tb_top;

    localparam int CLK_HALF = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] local_id;
    logic       msg_valid;
    logic       msg_dest_mode;
    logic [7:0] msg_dest;
    logic [2:0] msg_mode;
    logic [7:0] msg_vector;
    logic       msg_trig;
    logic       fix_valid;
    logic [7:0] fix_vector;
    logic       fix_trig;
    logic       fixed_ready;
    logic [7:0] fixed_vector;
    logic       int_enable;
    logic       ack;
    logic       irq_req;
    logic [2:0] irq_kind;
    logic [7:0] irq_vector;
    logic       fix_ack;

    int checks = 0;
    int errors = 0;

    logic [3:0]      m_pend;
    logic [3:0][7:0] m_vec;

    always #CLK_HALF clk = ~clk;

    irq_intake_sel dut_i (
        .clk(clk), .rst(rst), .local_id(local_id), .msg_valid(msg_valid),
        .msg_dest_mode(msg_dest_mode), .msg_dest(msg_dest), .msg_mode(msg_mode),
        .msg_vector(msg_vector), .msg_trig(msg_trig), .fix_valid(fix_valid),
        .fix_vector(fix_vector), .fix_trig(fix_trig), .fixed_ready(fixed_ready),
        .fixed_vector(fixed_vector), .int_enable(int_enable), .ack(ack),
        .irq_req(irq_req), .irq_kind(irq_kind), .irq_vector(irq_vector),
        .fix_ack(fix_ack)
    );

    function automatic logic accepted();
        if (!msg_valid) return 1'b0;
        if (msg_dest_mode) return msg_dest[local_id];
        return msg_dest == {5'd0, local_id};
    endfunction

    function automatic logic [2:0] exp_kind();
        if (m_pend[0]) return 3'd1;
        if (m_pend[1]) return 3'd2;
        if (m_pend[2]) return 3'd3;
        if (int_enable && m_pend[3]) return 3'd4;
        if (int_enable && fixed_ready) return 3'd5;
        return 3'd0;
    endfunction

    function automatic logic [7:0] exp_vec(input logic [2:0] k);
        case (k)
            3'd2: return m_vec[1];
            3'd3: return m_vec[2];
            3'd4: return m_vec[3];
            3'd5: return fixed_vector;
            default: return 8'd0;
        endcase
    endfunction

    function automatic int mode_src(input logic [2:0] m);
        case (m)
            3'd2: return 0;
            3'd4: return 1;
            3'd5: return 2;
            3'd7: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag);
        logic [2:0] k;
        logic       fv;
        logic [3:0] clr;
        int         s;
        #1;
        k  = exp_kind();
        fv = accepted() && (msg_mode == 3'd0 || msg_mode == 3'd1);
        chk(tag, "irq_req", 32'(irq_req), 32'(k != 3'd0));
        chk(tag, "irq_kind", 32'(irq_kind), 32'(k));
        chk(tag, "irq_vector", 32'(irq_vector), 32'(exp_vec(k)));
        chk(tag, "fix_valid", 32'(fix_valid), 32'(fv));
        chk(tag, "fix_vector", 32'(fix_vector), fv ? 32'(msg_vector) : 32'd0);
        chk(tag, "fix_trig", 32'(fix_trig), 32'(fv && msg_trig));
        chk(tag, "fix_ack", 32'(fix_ack), 32'(ack && k == 3'd5));
        @(posedge clk);
        clr = '0;
        if (ack && k >= 3'd1 && k <= 3'd4) clr[k-1] = 1'b1;
        s = accepted() ? mode_src(msg_mode) : -1;
        if (rst) begin
            m_pend = '0;
            m_vec  = '0;
        end else begin
            m_pend = m_pend & ~clr;
            if (s >= 0 && !m_pend[s]) begin
                m_pend[s] = 1'b1;
                m_vec[s]  = (s == 0) ? 8'd0 : msg_vector;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        msg_valid = 0; msg_dest_mode = 0; msg_dest = 0; msg_mode = 0;
        msg_vector = 0; msg_trig = 0; ack = 0; fixed_ready = 0;
        fixed_vector = 0; int_enable = 0; rst = 0;
    endtask

    task automatic send(input logic dm, input logic [7:0] dst,
                        input logic [2:0] md, input logic [7:0] v);
        msg_valid = 1; msg_dest_mode = dm; msg_dest = dst;
        msg_mode = md; msg_vector = v;
    endtask

    initial begin
        #(CLK_HALF * 2 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        local_id = 3'd5;
        idle();
        rst = 1;
        m_pend = '0;
        m_vec  = '0;
        @(negedge clk);
        @(negedge clk);
        step("R10");
        rst = 0;
        int_enable = 1;
        step("R10");

        // R1: address mismatch in both modes, then matches
        send(0, 8'd4, 3'd4, 8'h31); step("R1");
        send(1, 8'hDF, 3'd4, 8'h32); step("R1");
        send(1, 8'h20, 3'd4, 8'h33); step("R1");
        idle(); int_enable = 1; step("R1");
        ack = 1; step("R8");
        idle(); send(0, 8'd5, 3'd7, 8'h44); step("R1");
        idle(); step("R6");
        int_enable = 1; step("R6");

        // R3: reserved codes
        send(0, 8'd5, 3'd3, 8'h55); step("R3");
        send(0, 8'd5, 3'd6, 8'h56); step("R3");
        idle(); int_enable = 1; step("R3");

        // R4: duplicate NMI keeps first vector
        send(0, 8'd5, 3'd4, 8'hA1); step("R4");
        send(0, 8'd5, 3'd4, 8'hA2); step("R4");
        idle(); step("R4");

        // R9: ack and new NMI in the same cycle
        ack = 1; send(0, 8'd5, 3'd4, 8'hB7); step("R9");
        idle(); int_enable = 0; step("R9");

        // R7: full precedence with everything pending
        send(0, 8'd5, 3'd2, 8'h11); step("R7");
        send(0, 8'd5, 3'd5, 8'h22); step("R7");
        idle(); int_enable = 1; fixed_ready = 1; fixed_vector = 8'h77;
        for (int i = 0; i < 6; i++) begin
            ack = 1; step("R7");
        end
        ack = 0; fixed_ready = 0; step("R8");

        // R2: forwarded vectored messages
        send(1, 8'h20, 3'd0, 8'hC3); msg_trig = 1; step("R2");
        send(0, 8'd5, 3'd1, 8'hC4); msg_trig = 0; step("R2");

        // R10: reset while sources pending
        idle(); send(0, 8'd5, 3'd2, 8'h01); step("R10");
        idle(); rst = 1; step("R10");
        rst = 0; step("R10");

        // random mix (R5, R6, R8 and the rest)
        for (int n = 0; n < 3000; n++) begin
            msg_valid     = ($urandom % 3) != 0;
            msg_dest_mode = $urandom % 2;
            if ($urandom % 2) msg_dest = msg_dest_mode ? 8'(1 << 5) : 8'd5;
            else msg_dest = 8'($urandom);
            msg_mode     = 3'($urandom);
            msg_vector   = 8'($urandom);
            msg_trig     = $urandom % 2;
            ack          = ($urandom % 3) == 0;
            int_enable   = ($urandom % 4) != 0;
            fixed_ready  = $urandom % 2;
            fixed_vector = 8'($urandom);
            rst          = ($urandom % 200) == 0;
            step((n % 2 == 0) ? "R5" : "R6");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule